// File: doc/BRIEF.md
# PLL Power Sequencer

This controller brings an external phase-locked loop up and down in a safe order. In manual mode it drives three control lines of the PLL: bypass release, an active-low reset and an output gate. It steps them in a fixed order, waits a fixed settling time, and then polls the lock indication a bounded number of times. In vote mode it steps nothing itself. It raises a single vote line toward a shared arbiter and polls that arbiter's active flag instead.

Enable and disable requests arrive as single-cycle pulses. A small configuration word selects vote mode and holds two 6-bit count fields. A 32-bit status word presents the configuration and the live control and indication bits at fixed positions. Status outputs give busy, a one-cycle done pulse and a sticky timeout flag. All waits are derived from one parameter: the number of reference clock cycles in a microsecond.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset, all four PLL-facing outputs, busy, done and timeout are low. The status word equals zero while lock and active are low.
- R2: The status word carries these fields, which are captured from `cfg_wdata` at the same positions:
  - bit 0: output gate
  - bit 1: bypass release
  - bit 2: reset release
  - bits 13:8: lock-count field
  - bits 19:14: bias-count field
  - bit 20: vote-mode select
  - bit 21: vote reset field
  - bit 30: live active input
  - bit 31: live lock input
- R3: A manual enable raises bypass release one cycle after the request. It raises reset release exactly SETTLE_US*CYC_PER_US cycles later, and busy is high throughout.
- R4: Lock is first polled in the cycle after reset release and then once every CYC_PER_US cycles. In the cycle that a poll sees lock, the output gate rises, done pulses high for one cycle and busy drops.
- R5: If LOCK_POLLS consecutive polls fail, the following happens together: bypass, reset release and the output gate all go low, the timeout flag sets, busy drops, and done does not pulse.
- R6: In vote mode an enable only raises the vote and then polls the active input on the same schedule, starting the cycle after the vote. The lock input is ignored, and the three manual controls stay low.
- R7: A manual enable with the output gate, reset release and bypass release already high completes with a done pulse the next cycle. Busy stays low and no control changes.
- R8: A manual disable lowers the output gate first. After OFF_CYC cycles (one microsecond) it lowers reset release and bypass release in the same cycle, together with a done pulse.
- R9: A disable in vote mode only drops the vote, with a done pulse the next cycle.
- R10: Enable requests, disable requests and configuration writes that arrive while busy have no effect.
- R11: The timeout flag stays set until the next sequenced enable is accepted, which clears it in the cycle its first step appears.
- R12: A vote-mode timeout also withdraws the vote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word (bits 8 to 21 used) |
| req_on | input | 1 | Enable request pulse |
| req_off | input | 1 | Disable request pulse (wins over req_on) |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_active | input | 1 | Active flag from the vote arbiter |
| pll_bypass_rel | output | 1 | Bypass release to the PLL |
| pll_reset_n | output | 1 | Active-low reset to the PLL (high = released) |
| pll_out_en | output | 1 | Output gate to the PLL |
| pll_vote | output | 1 | Vote toward the arbiter |
| mode_word | output | 32 | Status word |
| seq_busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle completion pulse |
| seq_timeout | output | 1 | Sticky lock/active timeout |

## Verification
Manual enables are run against several lock arrival times: immediately at the first poll, between polls, and never. These cases separate the poll cadence, the exact settling gap and the timeout count. Vote-mode enables are run with lock held high and active arriving late or never. This shows that only the active flag is watched and that no local control moves. Requests repeated while already on, and requests and configuration writes issued in the middle of a sequence, distinguish the skip path from the ignore rule. A timeout followed by a new enable shows that the sticky flag clears only at that point.

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl #(
  parameter int CYC_PER_US = 20,
  parameter int SETTLE_US  = 5,
  parameter int LOCK_POLLS = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        req_on,
  input  logic        req_off,
  input  logic        pll_lock,
  input  logic        pll_active,
  output logic        pll_bypass_rel,
  output logic        pll_reset_n,
  output logic        pll_out_en,
  output logic        pll_vote,
  output logic [31:0] mode_word,
  output logic        seq_busy,
  output logic        seq_done,
  output logic        seq_timeout
);

  localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
  localparam int OFF_CYC    = CYC_PER_US;
  localparam int TW         = $clog2(SETTLE_CYC + CYC_PER_US + 1);
  localparam int PW         = $clog2(LOCK_POLLS + 1);
  localparam int AW         = $clog2(SETTLE_CYC + 2);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_POLL, S_DRAIN} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [PW-1:0] polls;
  logic [5:0]    lock_cnt, bias_cnt;
  logic          vote_en, vote_rst;

  wire all_on   = pll_out_en & pll_reset_n & pll_bypass_rel;
  wire poll_ok  = vote_en ? pll_active : pll_lock;
  wire poll_now = (tmr == '0);
  wire us_wrap  = (tmr == TW'(CYC_PER_US - 1));

  logic unused_wbits;
  assign unused_wbits = ^{cfg_wdata[31:22], cfg_wdata[7:0]};

  assign seq_busy  = (st != S_IDLE);
  assign mode_word = {pll_lock, pll_active, 8'b0, vote_rst, vote_en, bias_cnt, lock_cnt,
                      5'b0, pll_reset_n, pll_bypass_rel, pll_out_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      tmr            <= '0;
      polls          <= '0;
      lock_cnt       <= '0;
      bias_cnt       <= '0;
      vote_en        <= 1'b0;
      vote_rst       <= 1'b0;
      pll_bypass_rel <= 1'b0;
      pll_reset_n    <= 1'b0;
      pll_out_en     <= 1'b0;
      pll_vote       <= 1'b0;
      seq_done       <= 1'b0;
      seq_timeout    <= 1'b0;
    end else begin
      seq_done <= 1'b0;
      if (st == S_IDLE && cfg_we) begin
        lock_cnt <= cfg_wdata[13:8];
        bias_cnt <= cfg_wdata[19:14];
        vote_en  <= cfg_wdata[20];
        vote_rst <= cfg_wdata[21];
      end
      case (st)
        S_IDLE: begin
          if (req_off) begin
            if (vote_en) begin
              pll_vote <= 1'b0;
              seq_done <= 1'b1;
            end else begin
              pll_out_en <= 1'b0;
              tmr        <= '0;
              st         <= S_DRAIN;
            end
          end else if (req_on) begin
            if (vote_en) begin
              pll_vote    <= 1'b1;
              seq_timeout <= 1'b0;
              tmr         <= '0;
              polls       <= '0;
              st          <= S_POLL;
            end else if (all_on) begin
              seq_done <= 1'b1;
            end else begin
              pll_bypass_rel <= 1'b1;
              seq_timeout    <= 1'b0;
              tmr            <= '0;
              st             <= S_SETTLE;
            end
          end
        end
        S_SETTLE: begin
          if (tmr == TW'(SETTLE_CYC - 1)) begin
            pll_reset_n <= 1'b1;
            tmr         <= '0;
            polls       <= '0;
            st          <= S_POLL;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_POLL: begin
          tmr <= us_wrap ? '0 : tmr + 1'b1;
          if (poll_now) begin
            if (poll_ok) begin
              if (!vote_en) pll_out_en <= 1'b1;
              seq_done <= 1'b1;
              st       <= S_IDLE;
            end else if (polls == PW'(LOCK_POLLS - 1)) begin
              pll_bypass_rel <= 1'b0;
              pll_reset_n    <= 1'b0;
              pll_out_en     <= 1'b0;
              pll_vote       <= 1'b0;
              seq_timeout    <= 1'b1;
              st             <= S_IDLE;
            end else begin
              polls <= polls + 1'b1;
            end
          end
        end
        S_DRAIN: begin
          if (tmr == TW'(OFF_CYC - 1)) begin
            pll_reset_n    <= 1'b0;
            pll_bypass_rel <= 1'b0;
            seq_done       <= 1'b1;
            st             <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [AW-1:0] byp_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        byp_age <= '0;
    else if (!pll_bypass_rel)          byp_age <= '0;
    else if (byp_age < AW'(SETTLE_CYC)) byp_age <= byp_age + 1'b1;
  end

  a_r3_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_reset_n) |-> byp_age >= AW'(SETTLE_CYC));
  a_r3_reset_needs_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    pll_reset_n |-> pll_bypass_rel);
  a_r4_gate_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
    pll_out_en |-> pll_reset_n);
  a_r5_timeout_safe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_timeout) |-> !pll_out_en && !pll_reset_n && !pll_bypass_rel && !pll_vote);
  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !seq_busy);
  a_r8_drop_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_bypass_rel) |-> $fell(pll_reset_n));
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> $stable(mode_word[21:8]));

endmodule

// File: tb/test_pll_seq_ctrl.sv
module test_pll_seq_ctrl;
  localparam int CYC   = 4;
  localparam int SET   = 5 * CYC;
  localparam int POLLS = 5;
  localparam int OFF   = CYC;

  localparam logic [6:0] B = 7'd64, D = 7'd32, T = 7'd16, V = 7'd8, O = 7'd4, R = 7'd2, Y = 7'd1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, req_on = 1'b0, req_off = 1'b0, pll_lock = 1'b0, pll_active = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic pll_bypass_rel, pll_reset_n, pll_out_en, pll_vote, seq_busy, seq_done, seq_timeout;
  logic [31:0] mode_word;

  pll_seq_ctrl #(.CYC_PER_US(CYC), .SETTLE_US(5), .LOCK_POLLS(POLLS)) i_pll_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_on(req_on), .req_off(req_off), .pll_lock(pll_lock), .pll_active(pll_active),
    .pll_bypass_rel(pll_bypass_rel), .pll_reset_n(pll_reset_n), .pll_out_en(pll_out_en),
    .pll_vote(pll_vote), .mode_word(mode_word), .seq_busy(seq_busy),
    .seq_done(seq_done), .seq_timeout(seq_timeout));

  always #2 clk = ~clk;

  int cyc = 0, checks = 0, errors = 0;
  bit finished = 1'b0, mon_on = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  int         q_at[$];
  logic [6:0] q_v[$];
  string      q_tag[$];
  logic [6:0] cur, prev;
  int         e_at;
  logic [6:0] e_v;
  string      e_tag;

  function automatic logic [6:0] outs();
    return {seq_busy, seq_done, seq_timeout, pll_vote, pll_out_en, pll_reset_n, pll_bypass_rel};
  endfunction

  task automatic push(input int at, input logic [6:0] v, input string tag);
    q_at.push_back(at); q_v.push_back(v); q_tag.push_back(tag);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got=%h expected=%h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    cur = outs();
    if (cur !== prev) begin
      checks++;
      if (q_at.size() == 0) begin
        errors++;
        $display("FAIL unexpected change at cycle %0d: got=%b expected=%b", cyc, cur, prev);
      end else begin
        e_at = q_at.pop_front(); e_v = q_v.pop_front(); e_tag = q_tag.pop_front();
        if (e_at != cyc || e_v !== cur) begin
          errors++;
          $display("FAIL %s: got=%b at cycle %0d expected=%b at cycle %0d", e_tag, cur, cyc, e_v, e_at);
        end
      end
      prev = cur;
    end
  end

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic pulse(input bit on);
    if (on) req_on = 1'b1; else req_off = 1'b1;
    @(negedge clk);
    req_on = 1'b0; req_off = 1'b0;
  endtask

  task automatic en_manual(input int lock_after, input bit never, input bit poke);
    int c, l, p, last;
    c = cyc; l = c + 1 + SET;
    push(c + 1, B | Y, "R3 bypass first");
    push(l, B | R | Y, "R3 reset after settle");
    p = never ? POLLS : (lock_after + CYC - 1) / CYC;
    if (p >= POLLS) begin
      last = l + 1 + (POLLS - 1) * CYC;
      push(last, T, "R5 lock timeout");
    end else begin
      last = l + 1 + p * CYC + 1;
      push(last - 1, D | O | R | Y, "R4 lock seen");
      push(last, O | R | Y, "R4 done one cycle");
    end
    pulse(1'b1);
    if (poke) begin
      wait_to(c + 3);
      cfg_we = 1'b1; cfg_wdata = 32'h0010_0000; req_off = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; req_off = 1'b0;
    end
    if (!never) begin
      wait_to(l + lock_after);
      pll_lock = 1'b1;
    end
    wait_to(last + 1);
  endtask

  task automatic en_vote(input int act_after, input bit never);
    int c, p, last;
    c = cyc;
    push(c + 1, B | V, "R6 vote raised");
    p = never ? POLLS : (act_after + CYC - 1) / CYC;
    if (p >= POLLS) begin
      last = c + 2 + (POLLS - 1) * CYC;
      push(last, T, "R12 vote timeout");
    end else begin
      last = c + 2 + p * CYC + 1;
      push(last - 1, D | V, "R6 active seen");
      push(last, V, "R6 done one cycle");
    end
    pulse(1'b1);
    if (!never) begin
      wait_to(c + 1 + act_after);
      pll_active = 1'b1;
    end
    wait_to(last + 1);
  endtask

  task automatic dis_manual();
    int c;
    c = cyc;
    push(c + 1, B | R | Y, "R8 gate off first");
    push(c + 1 + OFF, D, "R8 reset and bypass together");
    push(c + 2 + OFF, 7'd0, "R8 done one cycle");
    pulse(1'b0);
    wait_to(c + 3 + OFF);
    pll_lock = 1'b0;
  endtask

  task automatic dis_vote();
    int c;
    c = cyc;
    push(c + 1, D, "R9 vote withdrawn");
    push(c + 2, 7'd0, "R9 done one cycle");
    pulse(1'b0);
    wait_to(c + 3);
    pll_active = 1'b0;
  endtask

  task automatic en_skip();
    int c;
    c = cyc;
    push(c + 1, D | O | R | Y, "R7 skip done");
    push(c + 2, O | R | Y, "R7 no change");
    pulse(1'b1);
    wait_to(c + 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outs() == 7'd0, "R1 reset outputs", 32'(outs()), 32'd0);
    chk(mode_word == 32'd0, "R1 reset status word", mode_word, 32'd0);
    prev = outs(); mon_on = 1'b1;

    cfg_we = 1'b1; cfg_wdata = (32'h15 << 14) | (32'h2A << 8);
    @(negedge clk); cfg_we = 1'b0;
    chk(mode_word[13:8] == 6'h2A, "R2 lock-count field", 32'(mode_word[13:8]), 32'h2A);
    chk(mode_word[19:14] == 6'h15, "R2 bias-count field", 32'(mode_word[19:14]), 32'h15);

    en_manual(7, 1'b0, 1'b1);
    chk(mode_word[20] == 1'b0, "R10 write ignored while busy", 32'(mode_word[20]), 32'd0);
    chk(mode_word[2:0] == 3'b111, "R2 control bits", 32'(mode_word[2:0]), 32'd7);
    chk(mode_word[31:30] == 2'b10, "R2 lock and active bits", 32'(mode_word[31:30]), 32'd2);

    en_skip();
    dis_manual();

    en_manual(0, 1'b1, 1'b0);
    repeat (30) @(negedge clk);
    chk(seq_timeout == 1'b1, "R11 timeout sticky", 32'(seq_timeout), 32'd1);
    chk(mode_word[2:0] == 3'b000, "R5 controls low after timeout", 32'(mode_word[2:0]), 32'd0);

    en_manual(0, 1'b0, 1'b0);
    chk(seq_timeout == 1'b0, "R11 cleared by enable", 32'(seq_timeout), 32'd0);
    dis_manual();

    cfg_we = 1'b1; cfg_wdata = (32'd1 << 20) | (32'h15 << 14) | (32'h2A << 8);
    @(negedge clk); cfg_we = 1'b0;
    chk(mode_word[20] == 1'b1, "R2 vote select bit", 32'(mode_word[20]), 32'd1);

    pll_lock = 1'b1;
    en_vote(9, 1'b0);
    dis_vote();
    en_vote(0, 1'b1);
    pll_lock = 1'b0;
    repeat (10) @(negedge clk);
    chk(pll_vote == 1'b0 && seq_timeout == 1'b1, "R12 vote timeout state",
        32'({pll_vote, seq_timeout}), 32'd1);

    chk(q_at.size() == 0, "R4 all expected events seen", 32'(q_at.size()), 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait (cyc > 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule